// File: doc/BRIEF.md
# Three-Phase Gate Command Decoder

This block turns logic-level PWM commands from a motor controller into six gate-enable outputs. There is one high-side and one low-side output for each of the phases A, B and C of a three-phase half-bridge power stage. A 2-bit mode input selects how the inputs are read. In the first mode each of the six inputs commands its own gate. In the second, one input per phase picks either the high or the low gate. In the third, a single PWM line is combined with a 4-bit step code, and a built-in six-step commutation table drives all three phases, including the overlap (dwell) states between adjacent steps.

In single-PWM mode, the freewheel option input chooses between two behaviours. With active freewheeling, the low gate of every PWM-switched phase receives the inverse of PWM. With diode freewheeling, that low gate stays off. The decoded gate word passes through a parameterised chain of registers on the system clock, so the gates never see combinational glitches. A low enable forces every gate off. Dead time, handshaking and analog drive belong to the stage that follows this block.

Top module: `phase_gate_decoder`

## Requirements
- R1: While rst_n is low, all six gate outputs are 0.
- R2: When enable is 0, all six gate outputs are 0 PIPE_STAGES cycles later, whatever the other inputs are.
- R3: The high and low gate outputs of a phase (same bit index) are never 1 at the same time, in any mode.
- R4: With mode 2'b00 or 2'b11 (six-input mode), for each phase p: gate_hi[p] = 1 only when hi_in[p]=1 and lo_in[p]=0; gate_lo[p] = 1 only when lo_in[p]=1 and hi_in[p]=0; otherwise both are 0.
- R5: With mode 2'b01 (three-input mode), gate_hi[p] = hi_in[p] and gate_lo[p] = NOT hi_in[p]; lo_in has no effect.
- R6: With mode 2'b10 (single-PWM mode), PWM is hi_in[0] and the step code is {lo_in[0], hi_in[1], lo_in[1], hi_in[2]} (MSB first). Bit index 0/1/2 is phase A/B/C. The main steps are 0110 (A switched, B sink), 0100 (C switched, B sink), 1100 (C switched, A sink), 1000 (B switched, A sink), 1010 (B switched, C sink) and 0010 (A switched, C sink). The third phase has both gates off. A switched phase has gate_hi = PWM. A sink phase has gate_hi=0 and gate_lo=1.
- R7: The overlap codes 0101, 1101, 1001, 1011, 0011 and 0111 drive the union of the two adjacent main steps. The phase common to both steps keeps its role. The other phase, off in one step, takes the role it has in the other step.
- R8: Code 1110 (Align) switches A and sinks B and C. Code 0000 (Stop) and the unlisted codes 0001 and 1111 turn all six gates off.
- R9: In single-PWM mode with fw_active=1, the low gate of each switched phase equals NOT PWM.
- R10: In single-PWM mode with fw_active=0, the low gate of each switched phase is 0.
- R11: In single-PWM mode, lo_in[2] has no effect on any output.
- R12: Each output reflects the inputs sampled exactly PIPE_STAGES rising clock edges earlier (default 1) and does not change before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 0 forces all gates off |
| mode | input | 2 | Input mode select (00/11 six-input, 01 three-input, 10 single-PWM) |
| fw_active | input | 1 | Single-PWM freewheel: 1 active, 0 diode |
| hi_in | input | 3 | High-side command per phase (bit 0 = A) |
| lo_in | input | 3 | Low-side command per phase (bit 0 = A) |
| gate_hi | output | 3 | Registered high-side gate enables |
| gate_lo | output | 3 | Registered low-side gate enables |

## Verification
Every decoded result is due PIPE_STAGES rising edges after the inputs change. No decode path bypasses the output registers. The bench drives inputs at a falling edge, waits that many falling edges, and only then compares. The latency scenario also samples one nanosecond after the new inputs are applied, to confirm the old gate word is still present. The assertions delay a copy of the inputs by the same number of stages, so they compare outputs against inputs from the matching cycle.

// File: rtl/gdec_pkg.sv
package gdec_pkg;

   localparam int unsigned NPH = 3;

   typedef enum logic [1:0] {
      MODE_SIX_A = 2'b00,
      MODE_THREE = 2'b01,
      MODE_STEP  = 2'b10,
      MODE_SIX_B = 2'b11
   } gdec_mode_e;

   typedef enum logic [1:0] {
      ROLE_OFF  = 2'd0,
      ROLE_PWM  = 2'd1,
      ROLE_SINK = 2'd2
   } gdec_role_e;

   typedef struct packed {
      logic [NPH-1:0] hi;
      logic [NPH-1:0] lo;
   } gate_word_t;

endpackage

// File: rtl/gdec_indep.sv
module gdec_indep
   import gdec_pkg::*;
#(
   parameter bit FOLLOW_HIGH = 1'b0
) (
   input  logic [NPH-1:0] hi_cmd,
   input  logic [NPH-1:0] lo_cmd,
   output gate_word_t     word
);
   for (genvar p = 0; p < NPH; p++) begin : g_ph
      if (FOLLOW_HIGH) begin : g_three
         assign word.hi[p] = hi_cmd[p];
         assign word.lo[p] = ~hi_cmd[p];
      end else begin : g_six
         assign word.hi[p] = hi_cmd[p] & ~lo_cmd[p];
         assign word.lo[p] = lo_cmd[p] & ~hi_cmd[p];
      end
   end

   logic unused_lo;
   assign unused_lo = FOLLOW_HIGH ? ^lo_cmd : 1'b0;
endmodule

// File: rtl/gdec_step_table.sv
module gdec_step_table
   import gdec_pkg::*;
(
   input  logic [3:0] code,
   input  logic       pwm,
   input  logic       fw_active,
   output gate_word_t word
);
   gdec_role_e role [NPH];

   always_comb begin
      role[0] = ROLE_OFF;
      role[1] = ROLE_OFF;
      role[2] = ROLE_OFF;
      unique case (code)
         4'b0110: begin role[0] = ROLE_PWM;  role[1] = ROLE_SINK; end
         4'b0101: begin role[0] = ROLE_PWM;  role[1] = ROLE_SINK; role[2] = ROLE_PWM;  end
         4'b0100: begin role[1] = ROLE_SINK; role[2] = ROLE_PWM;  end
         4'b1101: begin role[0] = ROLE_SINK; role[1] = ROLE_SINK; role[2] = ROLE_PWM;  end
         4'b1100: begin role[0] = ROLE_SINK; role[2] = ROLE_PWM;  end
         4'b1001: begin role[0] = ROLE_SINK; role[1] = ROLE_PWM;  role[2] = ROLE_PWM;  end
         4'b1000: begin role[0] = ROLE_SINK; role[1] = ROLE_PWM;  end
         4'b1011: begin role[0] = ROLE_SINK; role[1] = ROLE_PWM;  role[2] = ROLE_SINK; end
         4'b1010: begin role[1] = ROLE_PWM;  role[2] = ROLE_SINK; end
         4'b0011: begin role[0] = ROLE_PWM;  role[1] = ROLE_PWM;  role[2] = ROLE_SINK; end
         4'b0010: begin role[0] = ROLE_PWM;  role[2] = ROLE_SINK; end
         4'b0111: begin role[0] = ROLE_PWM;  role[1] = ROLE_SINK; role[2] = ROLE_SINK; end
         4'b1110: begin role[0] = ROLE_PWM;  role[1] = ROLE_SINK; role[2] = ROLE_SINK; end
         default: ;
      endcase
   end

   for (genvar p = 0; p < NPH; p++) begin : g_ph
      always_comb begin
         word.hi[p] = 1'b0;
         word.lo[p] = 1'b0;
         case (role[p])
            ROLE_PWM: begin
               word.hi[p] = pwm;
               word.lo[p] = fw_active & ~pwm;
            end
            ROLE_SINK: word.lo[p] = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/gdec_out_pipe.sv
module gdec_out_pipe
   import gdec_pkg::*;
#(
   parameter int unsigned STAGES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  gate_word_t d,
   output gate_word_t q
);
   gate_word_t stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else if (s == 0) begin
            stage_q[s] <= d;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/phase_gate_decoder.sv
module phase_gate_decoder
   import gdec_pkg::*;
#(
   parameter int unsigned PIPE_STAGES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic [1:0] mode,
   input  logic       fw_active,
   input  logic [2:0] hi_in,
   input  logic [2:0] lo_in,
   output logic [2:0] gate_hi,
   output logic [2:0] gate_lo
);
   if (PIPE_STAGES < 1 || PIPE_STAGES > 8) begin : g_bad_stages
      $error("PIPE_STAGES must lie in 1..8");
   end

   gdec_mode_e mode_e;
   gate_word_t six_w, three_w, step_w, sel_w, out_w;
   logic [3:0] step_code;

   assign mode_e    = gdec_mode_e'(mode);
   assign step_code = {lo_in[0], hi_in[1], lo_in[1], hi_in[2]};

   gdec_indep #(.FOLLOW_HIGH(1'b0)) u_six (
      .hi_cmd (hi_in),
      .lo_cmd (lo_in),
      .word   (six_w)
   );

   gdec_indep #(.FOLLOW_HIGH(1'b1)) u_three (
      .hi_cmd (hi_in),
      .lo_cmd (lo_in),
      .word   (three_w)
   );

   gdec_step_table u_step (
      .code      (step_code),
      .pwm       (hi_in[0]),
      .fw_active (fw_active),
      .word      (step_w)
   );

   always_comb begin
      unique case (mode_e)
         MODE_THREE: sel_w = three_w;
         MODE_STEP:  sel_w = step_w;
         default:    sel_w = six_w;
      endcase
      if (!enable) sel_w = '0;
   end

   gdec_out_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sel_w),
      .q     (out_w)
   );

   assign gate_hi = out_w.hi;
   assign gate_lo = out_w.lo;
endmodule

// File: rtl/gdec_checker.sv
module gdec_checker #(
   parameter int unsigned PIPE_STAGES = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic [1:0] mode,
   input logic       fw_active,
   input logic [2:0] hi_in,
   input logic [2:0] lo_in,
   input logic [2:0] gate_hi,
   input logic [2:0] gate_lo
);
   logic [9:0] hist [PIPE_STAGES];

   for (genvar s = 0; s < PIPE_STAGES; s++) begin : g_h
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hist[s] <= '0;
         else if (s == 0) hist[s] <= {enable, mode, fw_active, hi_in, lo_in};
         else             hist[s] <= hist[(s == 0) ? 0 : s-1];
      end
   end

   logic       d_en, d_fw;
   logic [1:0] d_mode;
   logic [2:0] d_hi, d_lo;
   assign {d_en, d_mode, d_fw, d_hi, d_lo} = hist[PIPE_STAGES-1];

   p_no_shoot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi & gate_lo) == 3'b000);

   p_disable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !d_en |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

   p_six_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_en && (d_mode == 2'b00 || d_mode == 2'b11)) |->
         (gate_hi == (d_hi & ~d_lo) && gate_lo == (d_lo & ~d_hi)));

   p_three_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (d_en && d_mode == 2'b01) |-> (gate_hi == d_hi && gate_lo == ~d_hi));

   p_high_needs_pwm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_en && d_mode == 2'b10 && !d_hi[0]) |-> gate_hi == 3'b000);

   p_stop_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (d_en && d_mode == 2'b10 && {d_lo[0], d_hi[1], d_lo[1], d_hi[2]} == 4'b0000)
         |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

   p_diode_pwm_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (d_en && d_mode == 2'b10 && !d_fw && d_hi[0]) |-> ((gate_lo & gate_hi) == 3'b000));
endmodule

bind phase_gate_decoder gdec_checker #(.PIPE_STAGES(PIPE_STAGES)) u_gdec_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .mode      (mode),
   .fw_active (fw_active),
   .hi_in     (hi_in),
   .lo_in     (lo_in),
   .gate_hi   (gate_hi),
   .gate_lo   (gate_lo)
);

// File: tb/test_phase_gate_decoder.sv
module test_phase_gate_decoder;
   localparam int LAT = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       fw_active = 1'b1;
   logic [2:0] hi_in = '0;
   logic [2:0] lo_in = '0;
   logic [2:0] gate_hi, gate_lo;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   phase_gate_decoder #(.PIPE_STAGES(LAT)) i_phase_gate_decoder (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
      .fw_active(fw_active), .hi_in(hi_in), .lo_in(lo_in),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   task automatic check(input string req, input logic [2:0] eh, input logic [2:0] el);
      checks++;
      if (gate_hi !== eh || gate_lo !== el) begin
         errors++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, gate_hi, gate_lo, eh, el);
      end
      checks++;
      if ((gate_hi & gate_lo) !== 3'b000) begin
         errors++;
         $display("FAIL R3: hi=%b lo=%b expected no overlap", gate_hi, gate_lo);
      end
   endtask

   task automatic apply(input logic en, input logic [1:0] m, input logic fw,
                        input logic [2:0] h, input logic [2:0] l);
      @(negedge clk);
      enable = en; mode = m; fw_active = fw; hi_in = h; lo_in = l;
      repeat (LAT) @(negedge clk);
   endtask

   // Phase roles for a step code, written per code as text: P switched, S sink, O off; char 0 = A
   function automatic string roles(input logic [3:0] c);
      case (c)
         4'b0110: return "PSO";  4'b0101: return "PSP";
         4'b0100: return "OSP";  4'b1101: return "SSP";
         4'b1100: return "SOP";  4'b1001: return "SPP";
         4'b1000: return "SPO";  4'b1011: return "SPS";
         4'b1010: return "OPS";  4'b0011: return "PPS";
         4'b0010: return "POS";  4'b0111: return "PSS";
         4'b1110: return "PSS";
         default: return "OOO";
      endcase
   endfunction

   task automatic step_case(input logic [3:0] c, input logic pwm, input logic fw,
                            input logic xc, input string req);
      string r;
      logic [2:0] eh, el;
      r = roles(c);
      for (int p = 0; p < 3; p++) begin
         eh[p] = (r[p] == "P") ? pwm : 1'b0;
         el[p] = (r[p] == "S") ? 1'b1 : ((r[p] == "P") ? (fw & ~pwm) : 1'b0);
      end
      apply(1'b1, 2'b10, fw, {c[0], c[2], pwm}, {xc, c[1], c[3]});
      check(req, eh, el);
   endtask

   task automatic t_reset;
      #5;
      check("R1", 3'b000, 3'b000);
      enable = 1'b1; mode = 2'b01; hi_in = 3'b101;
      @(negedge clk);
      check("R1", 3'b000, 3'b000);
      rst_n = 1'b1;
   endtask

   task automatic t_six_input;
      apply(1'b1, 2'b00, 1'b1, 3'b011, 3'b110);
      check("R4", 3'b001, 3'b100);
      apply(1'b1, 2'b11, 1'b0, 3'b100, 3'b011);
      check("R4", 3'b100, 3'b011);
      apply(1'b1, 2'b11, 1'b1, 3'b111, 3'b111);
      check("R4", 3'b000, 3'b000);
      apply(1'b1, 2'b00, 1'b1, 3'b000, 3'b000);
      check("R4", 3'b000, 3'b000);
   endtask

   task automatic t_three_input;
      apply(1'b1, 2'b01, 1'b1, 3'b101, 3'b000);
      check("R5", 3'b101, 3'b010);
      apply(1'b1, 2'b01, 1'b1, 3'b101, 3'b111);
      check("R5", 3'b101, 3'b010);
      apply(1'b1, 2'b01, 1'b0, 3'b010, 3'b101);
      check("R5", 3'b010, 3'b101);
   endtask

   task automatic t_enable;
      apply(1'b0, 2'b01, 1'b1, 3'b111, 3'b000);
      check("R2", 3'b000, 3'b000);
      apply(1'b0, 2'b10, 1'b1, 3'b001, 3'b010);
      check("R2", 3'b000, 3'b000);
   endtask

   task automatic t_main_steps;
      logic [3:0] codes [6] = '{4'b0110, 4'b0100, 4'b1100, 4'b1000, 4'b1010, 4'b0010};
      foreach (codes[i]) begin
         step_case(codes[i], 1'b1, 1'b1, 1'b0, "R6");
         step_case(codes[i], 1'b0, 1'b1, 1'b0, "R9");
         step_case(codes[i], 1'b1, 1'b0, 1'b0, "R10");
         step_case(codes[i], 1'b0, 1'b0, 1'b0, "R10");
      end
   endtask

   task automatic t_overlaps;
      logic [3:0] codes [6] = '{4'b0101, 4'b1101, 4'b1001, 4'b1011, 4'b0011, 4'b0111};
      foreach (codes[i]) begin
         step_case(codes[i], 1'b1, 1'b1, 1'b0, "R7");
         step_case(codes[i], 1'b0, 1'b1, 1'b0, "R7");
         step_case(codes[i], 1'b0, 1'b0, 1'b0, "R7");
      end
   endtask

   task automatic t_align_stop;
      step_case(4'b1110, 1'b1, 1'b1, 1'b0, "R8");
      step_case(4'b1110, 1'b0, 1'b1, 1'b0, "R8");
      step_case(4'b0000, 1'b1, 1'b1, 1'b0, "R8");
      step_case(4'b0001, 1'b1, 1'b1, 1'b0, "R8");
      step_case(4'b1111, 1'b0, 1'b1, 1'b0, "R8");
   endtask

   task automatic t_inlc_ignored;
      step_case(4'b0110, 1'b1, 1'b1, 1'b1, "R11");
      step_case(4'b0010, 1'b0, 1'b1, 1'b1, "R11");
      step_case(4'b0000, 1'b1, 1'b1, 1'b1, "R11");
      step_case(4'b1011, 1'b0, 1'b0, 1'b1, "R11");
   endtask

   task automatic t_latency;
      apply(1'b1, 2'b01, 1'b1, 3'b000, 3'b000);
      check("R12", 3'b000, 3'b111);
      @(negedge clk);
      hi_in = 3'b111;
      #1;
      check("R12", 3'b000, 3'b111);
      repeat (LAT) @(negedge clk);
      check("R12", 3'b111, 3'b000);
   endtask

   initial begin
      t_reset();
      t_six_input();
      t_three_input();
      t_enable();
      t_main_steps();
      t_overlaps();
      t_align_stop();
      t_inlc_ignored();
      t_latency();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected done=1");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule